// File: doc/BRIEF.md
# Banked Byte Data Memory with Shortcut Bank

This block is the byte-wide data store of a small processor core. The core sees a 12-bit data address space of 4096 bytes, divided into 16 banks of 256 bytes. Each access carries an 8-bit offset from the instruction, a one-bit bank-mode flag, and a 4-bit bank-select value held in a separate register. The block builds the 12-bit effective address from these, then performs a synchronous read or write.

With the bank-mode flag set, the bank-select value forms the top four address bits. With the flag clear, a shortcut bank is used and the bank-select value plays no part. Offsets below 80h reach the bottom half of bank 0, and offsets from 80h upward reach the top half of bank 15. That top half (F80h–FFFh) holds the special-function registers. These registers sit outside the block and are reached through a strobe-and-address port. Only the lowest `IMPL_BANKS` banks hold RAM. Every other location below F00h, and the range F00h–F7Fh, reads as zero and ignores writes.

Top module: `banked_data_mem`

## Requirements
- R1: After reset, `rdValid` is 0 and `rdData` is 00h until the first read completes.
- R2: When `accessBit` is 1, the effective address is `{bankSel, offset}`.
- R3: When `accessBit` is 0 and `offset` is below 80h, the effective address is `offset` in bank 0, whatever `bankSel` holds.
- R4: When `accessBit` is 0 and `offset` is 80h or above, the effective address is F00h plus `offset`, which is a special-function location, whatever `bankSel` holds.
- R5: Banks 0 to `IMPL_BANKS`-1 (default 4, addresses 000h–3FFh) store bytes. A read returns the byte last written to that address.
- R6: A read presented in cycle N drives `rdValid` high with its data in cycle N+1. `rdValid` is low after a write or an idle cycle.
- R7: A write followed by a read of the same address in the next cycle returns the newly written byte.
- R8: Unimplemented locations read 00h and ignore writes. These are banks `IMPL_BANKS` to 14, and F00h–F7Fh. A write to such a location does not change any implemented byte.
- R9: An access to F80h–FFFh raises `sfrStrobe` in the request cycle. In that cycle `sfrAddr` equals the low 7 bits of the effective address, `sfrWrite` equals `wrEn`, and `sfrWrData` equals `wrData`. The RAM is not written.
- R10: A special-function read returns, one cycle later, the `sfrRdData` value present during the request cycle.
- R11: With `reqValid` low, `sfrStrobe` stays low and no stored byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | An access is presented this cycle |
| wrEn | input | 1 | 1 = write, 0 = read |
| accessBit | input | 1 | 1 = use bank select, 0 = shortcut bank |
| bankSel | input | 4 | Bank select register value |
| offset | input | 8 | Offset from the instruction |
| wrData | input | DATA_W | Write byte |
| rdValid | output | 1 | Read data valid (one cycle after a read) |
| rdData | output | DATA_W | Read byte |
| sfrStrobe | output | 1 | Special-function access this cycle |
| sfrWrite | output | 1 | Special-function access is a write |
| sfrAddr | output | 7 | Special-function register index |
| sfrWrData | output | DATA_W | Special-function write byte |
| sfrRdData | input | DATA_W | Special-function read byte, same cycle as strobe |

## Verification
The assertions assume that `sfrRdData` is stable and valid during any cycle in which `sfrStrobe` is high. They also assume that `IMPL_BANKS` lies between 1 and 15, so that bank 0 always holds RAM and bank 15 never does. The bench drives every input half a cycle away from the clock edge. It models the special-function port as a combinational function of `sfrAddr`, so the read byte is always settled before the edge. It keeps the parameter at its default.

// File: rtl/bdm_pkg.sv
`timescale 1ns/1ps
package bdm_pkg;
  localparam int BANK_W = 4;
  localparam int OFS_W  = 8;
  localparam int ADDR_W = BANK_W + OFS_W;
  localparam int SFR_W  = OFS_W - 1;

  // strobes from control to datapath
  typedef struct packed {
    logic              ramWr;
    logic              ramRd;
    logic              sfrRd;
    logic              zeroRd;
    logic [BANK_W-1:0] bank;
    logic [OFS_W-1:0]  ofs;
  } bdmStrobe_t;

  typedef enum logic [1:0] {RGN_NONE, RGN_GPR, RGN_SFR} region_e;
  typedef enum logic [1:0] {SRC_ZERO, SRC_RAM, SRC_SFR} rdSrc_e;
endpackage

// File: rtl/bdm_ctrl.sv
`timescale 1ns/1ps
module bdm_ctrl
  import bdm_pkg::*;
#(
  parameter int IMPL_BANKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              wrEn,
  input  logic              accessBit,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [OFS_W-1:0]  offset,
  output bdmStrobe_t        st,
  output logic              sfrStrobe,
  output logic              sfrWrite,
  output logic [SFR_W-1:0]  sfrAddr
);
  localparam logic [BANK_W-1:0] TOP_BANK = {BANK_W{1'b1}};
  localparam logic [BANK_W-1:0] LOW_BANK = '0;

  logic [ADDR_W-1:0] effAddr;
  logic [BANK_W-1:0] effBank;
  logic              upperHalf;
  region_e           region;

  // effective address forming
  always_comb begin
    if (accessBit) effAddr = {bankSel, offset};
    else if (offset[OFS_W-1]) effAddr = {TOP_BANK, offset};
    else effAddr = {LOW_BANK, offset};
  end

  assign effBank   = effAddr[ADDR_W-1 -: BANK_W];
  assign upperHalf = effAddr[OFS_W-1];

  // region decode
  always_comb begin
    if (effBank == TOP_BANK && upperHalf) region = RGN_SFR;
    else if (int'(effBank) < IMPL_BANKS) region = RGN_GPR;
    else region = RGN_NONE;
  end

  always_comb begin
    st.bank   = effBank;
    st.ofs    = effAddr[OFS_W-1:0];
    st.ramWr  = reqValid && wrEn  && region == RGN_GPR;
    st.ramRd  = reqValid && !wrEn && region == RGN_GPR;
    st.sfrRd  = reqValid && !wrEn && region == RGN_SFR;
    st.zeroRd = reqValid && !wrEn && region == RGN_NONE;
  end

  assign sfrStrobe = reqValid && region == RGN_SFR;
  assign sfrWrite  = wrEn;
  assign sfrAddr   = effAddr[SFR_W-1:0];

  // R2: full banked address reaches the port for bank 15 upper half
  p_banked_sfr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accessBit && bankSel == TOP_BANK && offset[OFS_W-1])
      |-> (sfrStrobe && sfrAddr == offset[SFR_W-1:0]));

  // R3: shortcut low half always lands in bank 0 RAM
  p_short_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !accessBit && !offset[OFS_W-1])
      |-> (st.bank == LOW_BANK && (st.ramRd || st.ramWr) && !sfrStrobe));

  // R4: shortcut high half always reaches the register port
  p_short_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !accessBit && offset[OFS_W-1])
      |-> (sfrStrobe && sfrAddr == offset[SFR_W-1:0] && !st.ramWr && !st.ramRd));

  // R11: idle cycles touch nothing
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!sfrStrobe && !st.ramWr && !st.ramRd));

  // R9: at most one kind of action per cycle
  p_one_action_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.ramWr, st.ramRd, st.sfrRd, st.zeroRd}));
endmodule

// File: rtl/bdm_datapath.sv
`timescale 1ns/1ps
module bdm_datapath
  import bdm_pkg::*;
#(
  parameter int IMPL_BANKS = 4,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bdmStrobe_t        st,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] sfrRdData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  localparam int BANK_DEPTH = 1 << OFS_W;

  logic [DATA_W-1:0] bankRd [IMPL_BANKS];
  rdSrc_e            srcQ;
  logic [BANK_W-1:0] bankQ;
  logic [DATA_W-1:0] sfrQ;

  // one storage array per implemented bank
  for (genvar b = 0; b < IMPL_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [BANK_DEPTH];
    logic [DATA_W-1:0] rdQ;
    logic              hit;
    assign hit = (st.bank == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (st.ramWr && hit) mem[st.ofs] <= wrData;
      if (st.ramRd && hit) rdQ <= mem[st.ofs];
    end
    assign bankRd[b] = rdQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ    <= SRC_ZERO;
      bankQ   <= '0;
      sfrQ    <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= st.ramRd || st.sfrRd || st.zeroRd;
      if (st.ramRd) begin
        srcQ  <= SRC_RAM;
        bankQ <= st.bank;
      end else if (st.sfrRd) begin
        srcQ <= SRC_SFR;
        sfrQ <= sfrRdData;
      end else if (st.zeroRd) begin
        srcQ <= SRC_ZERO;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (srcQ)
      SRC_RAM: begin
        for (int b = 0; b < IMPL_BANKS; b++)
          if (bankQ == BANK_W'(b)) rdData = bankRd[b];
      end
      SRC_SFR: rdData = sfrQ;
      default: rdData = '0;
    endcase
  end

  // R6: every read produces valid data in the next cycle
  p_rd_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.ramRd || st.sfrRd || st.zeroRd) |=> rdValid);

  // R6: writes alone never signal read data
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(st.ramRd || st.sfrRd || st.zeroRd) |=> !rdValid);

  // R8: unimplemented reads return zero
  p_zero_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.zeroRd |=> rdData == '0);

  // R10: register-port read data is returned one cycle later
  p_sfr_return_r10: assert property (@(posedge clk) disable iff (!rstN)
    st.sfrRd |=> rdData == $past(sfrRdData));
endmodule

// File: rtl/banked_data_mem.sv
`timescale 1ns/1ps
module banked_data_mem
  import bdm_pkg::*;
#(
  parameter int IMPL_BANKS = 4,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              wrEn,
  input  logic              accessBit,
  input  logic [3:0]        bankSel,
  input  logic [7:0]        offset,
  input  logic [DATA_W-1:0] wrData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              sfrStrobe,
  output logic              sfrWrite,
  output logic [6:0]        sfrAddr,
  output logic [DATA_W-1:0] sfrWrData,
  input  logic [DATA_W-1:0] sfrRdData
);
  bdmStrobe_t st;

  bdm_ctrl #(.IMPL_BANKS(IMPL_BANKS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .wrEn      (wrEn),
    .accessBit (accessBit),
    .bankSel   (bankSel),
    .offset    (offset),
    .st        (st),
    .sfrStrobe (sfrStrobe),
    .sfrWrite  (sfrWrite),
    .sfrAddr   (sfrAddr)
  );

  bdm_datapath #(.IMPL_BANKS(IMPL_BANKS), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .wrData    (wrData),
    .sfrRdData (sfrRdData),
    .rdValid   (rdValid),
    .rdData    (rdData)
  );

  assign sfrWrData = wrData;
endmodule

// File: tb/banked_data_mem_tb.sv
`timescale 1ns/1ps
module banked_data_mem_tb;
  localparam int IMPL = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, wrEn = 1'b0, accessBit = 1'b0;
  logic [3:0] bankSel = '0;
  logic [7:0] offset = '0, wrData = '0;
  logic       rdValid, sfrStrobe, sfrWrite;
  logic [7:0] rdData, sfrWrData, sfrRdData;
  logic [6:0] sfrAddr;

  always #2 clk = ~clk;

  // register port model: a fixed function of the index
  assign sfrRdData = {1'b0, sfrAddr} ^ 8'hA5;

  banked_data_mem u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .wrEn(wrEn),
    .accessBit(accessBit), .bankSel(bankSel), .offset(offset),
    .wrData(wrData), .rdValid(rdValid), .rdData(rdData),
    .sfrStrobe(sfrStrobe), .sfrWrite(sfrWrite), .sfrAddr(sfrAddr),
    .sfrWrData(sfrWrData), .sfrRdData(sfrRdData)
  );

  int nVec = 0, nBad = 0;
  logic [7:0] refMem [4096];
  logic [7:0] expQ [$];
  string      tagQ [$];
  bit         done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] effA(input logic acc, input logic [3:0] bs, input logic [7:0] ofs);
    if (acc) return {bs, ofs};
    return ofs[7] ? {4'hF, ofs} : {4'h0, ofs};
  endfunction

  function automatic bit isSfr(input logic [11:0] a);
    return a >= 12'hF80;
  endfunction

  function automatic bit isRam(input logic [11:0] a);
    return int'(a[11:8]) < IMPL;
  endfunction

  // driver: one access per cycle, pushes expected read data
  task automatic access(input logic wr, input logic acc, input logic [3:0] bs,
                        input logic [7:0] ofs, input logic [7:0] wd, input string tag);
    logic [11:0] a;
    @(negedge clk);
    reqValid = 1'b1; wrEn = wr; accessBit = acc; bankSel = bs; offset = ofs; wrData = wd;
    a = effA(acc, bs, ofs);
    #1;
    check(sfrStrobe == isSfr(a), {tag, " R9 strobe"}, 16'(sfrStrobe), 16'(isSfr(a)));
    if (isSfr(a)) begin
      check(sfrAddr == a[6:0], {tag, " R9 addr"}, 16'(sfrAddr), 16'(a[6:0]));
      check(sfrWrite == wr, {tag, " R9 dir"}, 16'(sfrWrite), 16'(wr));
      if (wr) check(sfrWrData == wd, {tag, " R9 data"}, 16'(sfrWrData), 16'(wd));
    end
    if (wr) begin
      if (isRam(a)) refMem[a] = wd;
    end else begin
      if (isRam(a)) expQ.push_back(refMem[a]);
      else if (isSfr(a)) expQ.push_back({1'b0, a[6:0]} ^ 8'hA5);
      else expQ.push_back(8'h00);
      tagQ.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0; wrEn = 1'b1; offset = 8'h90; accessBit = 1'b0;
      #1;
      check(!sfrStrobe, "R11 idle strobe", 16'(sfrStrobe), 16'd0);
    end
  endtask

  // monitor: compares read results against the queue
  always @(negedge clk) begin
    if (rstN && !done && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected rdValid", 16'(rdValid), 16'd0);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData == e, t, 16'(rdData), 16'(e));
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      nVec++; nBad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    check(rdValid == 1'b0, "R1 reset rdValid", 16'(rdValid), 16'd0);
    check(rdData == 8'h00, "R1 reset rdData", 16'(rdData), 16'd0);
    @(negedge clk); rstN = 1'b1;
    #1;
    check(rdValid == 1'b0 && rdData == 8'h00, "R1 after release", 16'({rdValid, rdData}), 16'd0);

    // preload all implemented banks
    for (int a = 0; a < IMPL * 256; a++)
      access(1'b1, 1'b1, 4'(a >> 8), 8'(a), 8'(a * 7 + 3), "R5 preload");
    for (int b = 0; b < IMPL; b++)
      access(1'b0, 1'b1, 4'(b), 8'h42, 8'h00, "R5 readback");

    // R7: write then read next cycle
    access(1'b1, 1'b1, 4'd2, 8'h10, 8'hC3, "R7 write");
    access(1'b0, 1'b1, 4'd2, 8'h10, 8'h00, "R7 read-after-write");
    // R2 vs R3: shortcut low half ignores bank select
    access(1'b1, 1'b0, 4'd2, 8'h10, 8'h5E, "R3 shortcut write");
    access(1'b0, 1'b1, 4'd0, 8'h10, 8'h00, "R3 lands in bank0");
    access(1'b0, 1'b1, 4'd2, 8'h10, 8'h00, "R2 bank2 untouched");
    access(1'b0, 1'b0, 4'd9, 8'h10, 8'h00, "R3 shortcut read");
    // R4/R10: shortcut high half reaches register port
    access(1'b0, 1'b0, 4'd2, 8'h85, 8'h00, "R4 R10 shortcut sfr read");
    access(1'b1, 1'b0, 4'd1, 8'hFF, 8'h77, "R4 shortcut sfr write");
    access(1'b0, 1'b1, 4'd0, 8'hFF, 8'h00, "R9 bank0 not written");
    access(1'b0, 1'b1, 4'd15, 8'hC0, 8'h00, "R2 R10 banked sfr read");
    // R8: unimplemented regions
    access(1'b1, 1'b1, 4'd5, 8'h20, 8'hEE, "R8 write bank5");
    access(1'b0, 1'b1, 4'd5, 8'h20, 8'h00, "R8 read bank5");
    access(1'b0, 1'b1, 4'd1, 8'h20, 8'h00, "R8 no alias bank1");
    access(1'b1, 1'b1, 4'd15, 8'h30, 8'hEE, "R8 write F30");
    access(1'b0, 1'b1, 4'd15, 8'h30, 8'h00, "R8 read F30");
    access(1'b0, 1'b1, 4'd14, 8'hFF, 8'h00, "R8 read bank14");
    // R11: idle gaps then check storage
    idle(3);
    access(1'b0, 1'b1, 4'd0, 8'h90, 8'h00, "R11 storage after idle");
    idle(2);

    // mixed traffic across the whole space
    for (int i = 0; i < 3000; i++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      access(lfsr[31], lfsr[30], lfsr[27:24], lfsr[23:16], lfsr[15:8], "R2 R5 R8 R9 mixed");
      if (lfsr[5:0] == 6'd0) idle(1);
    end
    idle(3);
    check(expQ.size() == 0, "R6 all reads returned", 16'(expQ.size()), 16'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule